// File: doc/BRIEF.md
# Sliding-Window Event Rate Governor

This block estimates how busy an event stream is and turns that estimate into an operating-point index for the supply and clock control logic. It observes a one-cycle event strobe and a slow time-base tick. A fixed number of ticks makes one stride. Three event counters are started one stride apart, so each counter covers a window of three strides. At every stride boundary the counter that has run for a full window reports its count as the rate and then restarts. The rate therefore refreshes once per stride over an overlapping window, and no per-event timestamp is stored.

The reported rate is compared with an ascending list of thresholds. The result is the index of an operating point, where a higher index means a higher voltage and frequency. A change strobe is raised only when that index moves. The block only observes the event strobe, so it can sit beside the noise filter without holding up any event. Driving the regulator and the clock generator is left to the logic that consumes the index.

Top module: `rate_governor`

## Requirements
- R1: While `rst_n` is low, the outputs are `rate_o`=0, `rate_vld_o`=0, `op_chg_o`=0 and `op_idx_o`=NUM_OP-1, which is the highest-performance point.
- R2: A stride boundary is the clock cycle in which `tick_i` is high for the STRIDE_TICKS-th time since reset or since the previous boundary. Cycles without a tick never advance the stride, however many of them pass.
- R3: The first two boundaries after reset produce no report. The third boundary and every boundary after it produce one, and `rate_vld_o` is high for exactly the one cycle that follows the boundary cycle.
- R4: A report at boundary b gives the number of cycles with `evt_i` high from boundary b-3 up to boundary b, including b-3 and excluding b. Reset counts as boundary 0. An event that falls in a boundary cycle therefore belongs to the window that starts there.
- R5: Each counter saturates at 2^CNT_W-1 and does not wrap, so a saturated window reports exactly 2^CNT_W-1.
- R6: With the thresholds THR[0..NUM_OP-1] ascending and THR[0]=0 (the defaults are 0, 4, 12 and 24), every report sets `op_idx_o` to the largest i with THR[i] <= `rate_o`.
- R7: `op_chg_o` is high only in a `rate_vld_o` cycle, and only when the new `op_idx_o` differs from the previous one. `op_idx_o` changes in no other cycle.
- R8: Until the first report after reset, `op_idx_o` stays at NUM_OP-1 whatever the event traffic is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. It is asserted asynchronously and released in step with clk |
| evt_i | input | 1 | Event strobe. Each cycle it is high counts as one event |
| tick_i | input | 1 | Time-base tick. STRIDE_TICKS ticks make one stride |
| rate_o | output | CNT_W | Event count over the last three strides |
| rate_vld_o | output | 1 | One-cycle pulse when `rate_o` has been refreshed |
| op_idx_o | output | $clog2(NUM_OP) | Selected operating-point index |
| op_chg_o | output | 1 | One-cycle pulse when `op_idx_o` has taken a new value |

## Verification
The bench places an event inside a boundary cycle and checks that it shows up in the next report and not the current one. A design that counted it in the closing window would report one event too early. It holds the tick low for a long stretch to show that idle cycles do not close a stride; a design that timed strides in clock cycles would report early. A narrow-counter instance is driven with more events than it can hold, and it must report all ones; a wrapping counter would report the count modulo its range. The stimulus table walks the rate across every threshold, lands exactly on threshold values and repeats the same index. It also checks the two silent boundaries after reset. An off-by-one in the lookup would pick the wrong point, a missing warm-up would drop the high-performance point too early, and a change strobe without a compare would fire on repeated indices.

// File: rtl/rg_pkg.sv
package rg_pkg;

  // number of staggered window counters; the window spans this many strides
  localparam int unsigned NUM_CTR = 3;

  // warm-up phase after reset: two silent boundaries, then steady reporting
  typedef enum logic [1:0] {
    PH_FILL0 = 2'd0,
    PH_FILL1 = 2'd1,
    PH_RUN   = 2'd2
  } phase_e;

endpackage

// File: rtl/rg_stride_timer.sv
module rg_stride_timer #(
  parameter int unsigned STRIDE_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic stride_end_o
);

  localparam int unsigned TW = (STRIDE_TICKS > 1) ? $clog2(STRIDE_TICKS) : 1;
  localparam logic [TW-1:0] LAST = TW'(STRIDE_TICKS - 1);

  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          tcnt_en;
  logic          at_last;

  assign at_last      = (tcnt_q == LAST);
  assign tcnt_en      = tick_i;
  assign stride_end_o = tick_i && at_last;

  always_comb begin
    tcnt_d = tcnt_q;
    if (tcnt_en) begin
      if (at_last) begin
        tcnt_d = '0;
      end else begin
        tcnt_d = tcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
    end else if (tcnt_en) begin
      tcnt_q <= tcnt_d;
    end
  end

endmodule

// File: rtl/rg_win_counters.sv
module rg_win_counters #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             stride_end_i,
  output logic [CNT_W-1:0] oldest_cnt_o
);

  import rg_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // svc_ptr_q names the counter that will be served at the next boundary.
  // Counter 0 starts at reset, counter 1 at the first boundary, counter 2
  // at the second, so the pointer leaves reset at 1.
  logic [1:0]       svc_ptr_q, svc_ptr_d;
  logic [CNT_W-1:0] cnt_vec [NUM_CTR];

  always_comb begin
    svc_ptr_d = svc_ptr_q;
    if (stride_end_i) begin
      svc_ptr_d = (svc_ptr_q == 2'(NUM_CTR - 1)) ? 2'd0 : svc_ptr_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_ptr_q <= 2'd1;
    end else if (stride_end_i) begin
      svc_ptr_q <= svc_ptr_d;
    end
  end

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    logic             served;
    logic             cnt_en;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    assign served = stride_end_i && (svc_ptr_q == 2'(k));
    assign cnt_en = served || (evt_i && (cnt_q != CNT_MAX));

    always_comb begin
      if (served) begin
        // restart; an event in the boundary cycle opens the new window
        cnt_d = {{(CNT_W-1){1'b0}}, evt_i};
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end

    assign cnt_vec[k] = cnt_q;
  end

  always_comb begin
    case (svc_ptr_q)
      2'd0:    oldest_cnt_o = cnt_vec[0];
      2'd1:    oldest_cnt_o = cnt_vec[1];
      default: oldest_cnt_o = cnt_vec[2];
    endcase
  end

endmodule

// File: rtl/rg_op_select.sv
module rg_op_select #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned NUM_OP = 4,
  parameter logic [NUM_OP*CNT_W-1:0] THR = {8'd24, 8'd12, 8'd4, 8'd0}
) (
  input  logic [CNT_W-1:0]          rate_i,
  output logic [$clog2(NUM_OP)-1:0] idx_o
);

  localparam int unsigned IDX_W = $clog2(NUM_OP);

  // thresholds ascend, so the last entry that is met is the highest one met
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_OP; i++) begin
      if (THR[i*CNT_W +: CNT_W] <= rate_i) begin
        idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/rate_governor.sv
module rate_governor #(
  parameter int unsigned STRIDE_TICKS = 4,
  parameter int unsigned CNT_W        = 8,
  parameter int unsigned NUM_OP       = 4,
  parameter logic [NUM_OP*CNT_W-1:0] THR = {8'd24, 8'd12, 8'd4, 8'd0}
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      evt_i,
  input  logic                      tick_i,
  output logic [CNT_W-1:0]          rate_o,
  output logic                      rate_vld_o,
  output logic [$clog2(NUM_OP)-1:0] op_idx_o,
  output logic                      op_chg_o
);

  import rg_pkg::*;

  localparam int unsigned IDX_W = $clog2(NUM_OP);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(NUM_OP - 1);

  logic             stride_end;
  logic [CNT_W-1:0] oldest_cnt;
  logic [IDX_W-1:0] sel_idx;
  logic             report;

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] rate_q, rate_d;
  logic             vld_q, vld_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             chg_q, chg_d;

  rg_stride_timer #(
    .STRIDE_TICKS (STRIDE_TICKS)
  ) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .stride_end_o (stride_end)
  );

  rg_win_counters #(
    .CNT_W (CNT_W)
  ) u_ctrs (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_i        (evt_i),
    .stride_end_i (stride_end),
    .oldest_cnt_o (oldest_cnt)
  );

  rg_op_select #(
    .CNT_W  (CNT_W),
    .NUM_OP (NUM_OP),
    .THR    (THR)
  ) u_sel (
    .rate_i (oldest_cnt),
    .idx_o  (sel_idx)
  );

  assign report = stride_end && (phase_q == PH_RUN);

  // warm-up phase
  always_comb begin
    phase_d = phase_q;
    if (stride_end) begin
      case (phase_q)
        PH_FILL0: phase_d = PH_FILL1;
        PH_FILL1: phase_d = PH_RUN;
        default:  phase_d = PH_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FILL0;
    end else if (stride_end) begin
      phase_q <= phase_d;
    end
  end

  // report and operating-point registers
  always_comb begin
    vld_d  = report;
    rate_d = report ? oldest_cnt : rate_q;
    idx_d  = report ? sel_idx : idx_q;
    chg_d  = report && (sel_idx != idx_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      chg_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      chg_q <= chg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      idx_q  <= IDX_TOP;
    end else if (report) begin
      rate_q <= rate_d;
      idx_q  <= idx_d;
    end
  end

  assign rate_o     = rate_q;
  assign rate_vld_o = vld_q;
  assign op_idx_o   = idx_q;
  assign op_chg_o   = chg_q;

endmodule

// File: rtl/rg_checker.sv
module rg_checker #(
  parameter int unsigned STRIDE_TICKS = 4,
  parameter int unsigned CNT_W        = 8,
  parameter int unsigned NUM_OP       = 4,
  parameter logic [NUM_OP*CNT_W-1:0] THR = {8'd24, 8'd12, 8'd4, 8'd0}
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tick_i,
  input logic [CNT_W-1:0]          rate_o,
  input logic                      rate_vld_o,
  input logic [$clog2(NUM_OP)-1:0] op_idx_o,
  input logic                      op_chg_o
);

  localparam int unsigned IDX_W = $clog2(NUM_OP);
  localparam int unsigned TW    = (STRIDE_TICKS > 1) ? $clog2(STRIDE_TICKS) : 1;
  localparam logic [TW-1:0] LAST = TW'(STRIDE_TICKS - 1);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(NUM_OP - 1);

  function automatic logic [CNT_W-1:0] thr_at(input int unsigned i);
    return CNT_W'(THR >> (i * CNT_W));
  endfunction

  // independent model of boundary timing
  logic [TW-1:0] tk_q;
  logic [1:0]    nb_q;
  logic          exp_vld_q;
  logic          seen_q;
  logic          bnd;

  assign bnd = tick_i && (tk_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tk_q      <= '0;
      nb_q      <= 2'd0;
      exp_vld_q <= 1'b0;
      seen_q    <= 1'b0;
    end else begin
      if (tick_i) begin
        tk_q <= bnd ? '0 : tk_q + 1'b1;
      end
      if (bnd && (nb_q != 2'd2)) begin
        nb_q <= nb_q + 2'd1;
      end
      exp_vld_q <= bnd && (nb_q == 2'd2);
      seen_q    <= seen_q | rate_vld_o;
    end
  end

  AST_VLD_TIMING: assert property (@(posedge clk) disable iff (!rst_n) rate_vld_o == exp_vld_q); // R3
  AST_IDX_LOWER: assert property (@(posedge clk) disable iff (!rst_n) rate_vld_o |-> (thr_at(int'(op_idx_o)) <= rate_o)); // R6
  AST_IDX_UPPER: assert property (@(posedge clk) disable iff (!rst_n) (rate_vld_o && (op_idx_o != IDX_TOP)) |-> (thr_at(int'(op_idx_o) + 1) > rate_o)); // R6
  AST_CHG_IN_VLD: assert property (@(posedge clk) disable iff (!rst_n) op_chg_o |-> rate_vld_o); // R7
  AST_CHG_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n) rate_vld_o |-> (op_chg_o == (op_idx_o != $past(op_idx_o)))); // R7
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rate_vld_o |-> $stable(op_idx_o)); // R7
  AST_WARM_TOP: assert property (@(posedge clk) disable iff (!rst_n) (!seen_q && !rate_vld_o) |-> (op_idx_o == IDX_TOP)); // R8

endmodule

bind rate_governor rg_checker #(
  .STRIDE_TICKS (STRIDE_TICKS),
  .CNT_W        (CNT_W),
  .NUM_OP       (NUM_OP),
  .THR          (THR)
) u_rg_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .rate_o     (rate_o),
  .rate_vld_o (rate_vld_o),
  .op_idx_o   (op_idx_o),
  .op_chg_o   (op_chg_o)
);

// File: tb/test_rate_governor.sv
module test_rate_governor;

  logic       clk;
  logic       rst_n;
  logic       evt_i;
  logic       tick_i;
  logic [7:0] rate_o;
  logic       rate_vld_o;
  logic [1:0] op_idx_o;
  logic       op_chg_o;
  logic [3:0] s_rate;
  logic       s_vld;
  logic [1:0] s_idx;
  logic       s_chg;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // stride = 4 ticks, one tick every 8 cycles -> 32 cycles, boundary at cycle 31
  rate_governor #(
    .STRIDE_TICKS (4), .CNT_W (8), .NUM_OP (4),
    .THR ({8'd24, 8'd12, 8'd4, 8'd0})
  ) i_rate_governor (
    .clk (clk), .rst_n (rst_n), .evt_i (evt_i), .tick_i (tick_i),
    .rate_o (rate_o), .rate_vld_o (rate_vld_o),
    .op_idx_o (op_idx_o), .op_chg_o (op_chg_o)
  );

  // narrow counters to reach saturation
  rate_governor #(
    .STRIDE_TICKS (4), .CNT_W (4), .NUM_OP (4),
    .THR ({4'd12, 4'd8, 4'd4, 4'd0})
  ) i_rate_governor_sat (
    .clk (clk), .rst_n (rst_n), .evt_i (evt_i), .tick_i (tick_i),
    .rate_o (s_rate), .rate_vld_o (s_vld),
    .op_idx_o (s_idx), .op_chg_o (s_chg)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  localparam int NROW = 17;
  localparam int T_N    [NROW] = '{10, 0, 2, 2, 0, 0, 30, 30, 30, 3, 1, 1, 0, 3, 8, 1, 20};
  localparam int T_VLD  [NROW] = '{ 0, 0, 1, 1, 1, 1,  1,  1,  1, 1, 1, 1, 1, 1, 1, 1,  1};
  localparam int T_RATE [NROW] = '{ 0, 0,12, 4, 4, 2, 30, 60, 90,63,34, 5, 2, 4,11,12, 29};
  localparam int T_IDX  [NROW] = '{ 3, 3, 2, 1, 1, 0,  3,  3,  3, 3, 3, 1, 0, 1, 1, 2,  3};
  localparam int T_CHG  [NROW] = '{ 0, 0, 1, 1, 0, 1,  1,  0,  0, 0, 0, 1, 1, 1, 0, 1,  1};

  int mid_vld;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one stride: n events in cycles 0..n-1, optional event in boundary cycle 31
  task automatic run_stride(input int n, input bit bnd_evt);
    mid_vld = 0;
    for (int j = 0; j < 32; j++) begin
      evt_i  = (j < n) || (bnd_evt && (j == 31));
      tick_i = ((j % 8) == 7);
      @(negedge clk);
      if ((j < 31) && rate_vld_o) mid_vld++;
    end
    evt_i  = 1'b0;
    tick_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n  = 1'b0;
    evt_i  = 1'b0;
    tick_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 rate", int'(rate_o), 0);
    check("R1 vld", int'(rate_vld_o), 0);
    check("R1 chg", int'(op_chg_o), 0);
    check("R1 idx", int'(op_idx_o), 3);
    rst_n = 1'b1;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n  = 1'b0;
    evt_i  = 1'b0;
    tick_i = 1'b0;
    @(negedge clk);
    do_reset();
    check("R1 sat idx", int'(s_idx), 3);

    // table walk: R3 warm-up, R4 window sums, R6 lookup, R7 change, R8 hold
    for (int r = 0; r < NROW; r++) begin
      run_stride(T_N[r], 1'b0);
      check("R3 single pulse", mid_vld, 0);
      check("R3 vld", int'(rate_vld_o), T_VLD[r]);
      check("R4 rate", int'(rate_o), T_RATE[r]);
      check((r < 2) ? "R8 idx" : "R6 idx", int'(op_idx_o), T_IDX[r]);
      check("R7 chg", int'(op_chg_o), T_CHG[r]);
      @(negedge clk);
      check("R3 vld drop", int'(rate_vld_o), 0);
      // that extra cycle belongs to the next stride; it carries no tick or event
      // and only shifts the stride by one idle cycle, which R2 permits
    end

    // R2: idle cycles with no tick must not close a stride
    mid_vld = 0;
    for (int j = 0; j < 120; j++) begin
      tick_i = (j == 7) || (j == 15) || (j == 23);
      @(negedge clk);
      if (rate_vld_o) mid_vld++;
    end
    check("R2 no early boundary", mid_vld, 0);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    check("R2 boundary on 4th tick", int'(rate_vld_o), 1);
    check("R4 rate after gap", int'(rate_o), 21);
    check("R6 idx after gap", int'(op_idx_o), 2);

    // R4: event in the boundary cycle belongs to the next window
    do_reset();
    run_stride(0, 1'b0);
    run_stride(0, 1'b0);
    check("R8 idx before report", int'(op_idx_o), 3);
    run_stride(0, 1'b1);
    check("R4 boundary event excluded", int'(rate_o), 0);
    check("R6 idx at zero", int'(op_idx_o), 0);
    run_stride(0, 1'b0);
    check("R4 boundary event in next", int'(rate_o), 1);
    check("R7 no change", int'(op_chg_o), 0);

    // R5: saturation on the narrow instance
    do_reset();
    run_stride(31, 1'b0);
    run_stride(31, 1'b0);
    run_stride(31, 1'b0);
    check("R4 wide rate", int'(rate_o), 93);
    check("R7 wide chg same idx", int'(op_chg_o), 0);
    check("R5 sat vld", int'(s_vld), 1);
    check("R5 sat rate", int'(s_rate), 15);
    check("R6 sat idx", int'(s_idx), 3);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule